// File: doc/BRIEF.md
# Multichannel Audio Sample FIFO

This block buffers audio samples for one direction of a serial audio port. In playback the host writes samples through a data write port and the serial side pops them one at a time. In capture the serial side pushes samples and the host reads them through a data read port. The storage is a single word memory of `256 << SIZE_CODE` entries. The usable part depends on the channel count. Each channel gets the memory size divided by the channel count rounded up to a power of two, so modes with 3 or with 5 to 7 channels leave part of the memory unused.

A control register clears the FIFO, enables the half-level interrupt request, and selects 16-bit packing on the host side. The channel count pin and the direction pin are captured only when a clear is issued. A status register reports how many whole frames are held and carries two sticky error flags, overrun and underrun, which software clears by writing zero. Occupancy is tracked by a small state machine with three states. ST_EMPTY holds no words. ST_PARTIAL holds at least one word and is below capacity. ST_FULL holds exactly the usable capacity.

The transitions are:
- ST_EMPTY to ST_PARTIAL on an accepted push.
- ST_PARTIAL to ST_FULL on a push alone that reaches capacity.
- ST_PARTIAL to ST_EMPTY on a pop alone that removes the last word.
- ST_FULL to ST_PARTIAL on an accepted pop.
- Any state to ST_EMPTY on a clear.

Top module: `audio_sample_fifo`

## Requirements
- R1: Usable capacity in words is `(256 << SIZE_CODE) >> s` times the channel count, where `2**s` is the channel count rounded up to a power of two. With the default size this is 256 words for 1 channel, 192 for 3 channels and 160 for 5 channels.
- R2: Status bits [16:8] give the number of complete frames held, that is the words held divided by the channel count and rounded down, saturating at 511.
- R3: A producer write while the FIFO holds its full capacity sets the overrun flag (status bit 4) and the sample is discarded. This holds even if a consumer read happens in the same cycle.
- R4: A consumer read while the FIFO is empty sets the underrun flag (status bit 0), and the read port shows zero whenever the FIFO is empty.
- R5: Both error flags are sticky. A status register write ANDs each flag with the written bit at its position, so writing zero clears it. A new error in the same cycle as the write wins.
- R6: Writing the control register with bit 0 set empties the FIFO and sets the frame count to zero, leaving the error flags unchanged. A data operation in the same cycle is dropped.
- R7: The channel count and direction pins are captured only by a clear. A count of 0 is taken as 1 and a count above 8 is taken as 8.
- R8: Direction 0 (playback) fills from the host write port and drains through the stream pop. Direction 1 (capture) fills from the stream push and drains through the host read port. Operations on the two unused ports are ignored.
- R9: Samples leave in the order they entered. The head sample is shown on the active read port before it is popped.
- R10: With control bit 20 set, the request output is high when the words held are at or below half the capacity in playback, and at or above half the capacity in capture. With bit 20 clear, the request output is low.
- R11: With control bit 12 set, a host write stores bits [15:0] of the written value in sample bits [23:8] with zeros below them. A host read returns sample bits [23:8] in bits [15:0], with the upper bits zero.
- R12: After reset the FIFO is empty, both flags are zero, the control readback (bits 20 and 12) is zero, and the configuration is 1 channel in playback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_chan | input | 4 | Channel count, captured on clear |
| cfg_capture | input | 1 | Direction (1 = capture), captured on clear |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write value: bit 0 clear, bit 12 narrow, bit 20 request enable |
| ctl_rdata | output | 32 | Control readback (bits 20 and 12) |
| st_wr | input | 1 | Status register write strobe |
| st_wdata | input | 32 | Status write value (bits 4 and 0 used) |
| st_rdata | output | 32 | Status: frames [16:8], overrun bit 4, underrun bit 0 |
| host_wr | input | 1 | Host data write (playback producer) |
| host_wdata | input | 24 | Host write sample |
| host_rd | input | 1 | Host data read (capture consumer) |
| host_rdata | output | 24 | Head sample for host read |
| str_push | input | 1 | Stream push (capture producer) |
| str_pdata | input | 24 | Stream push sample |
| str_pop | input | 1 | Stream pop (playback consumer) |
| str_qdata | output | 24 | Head sample for stream pop |
| irq_req | output | 1 | Half-level request |

## Verification
The hardest case to reach from the ports is the exact capacity edge in the modes with 3 and 5 channels, where the FIFO refuses a sample even though memory words remain free. The bench reaches this edge by clearing with each channel count and then writing back-to-back samples up to the rounded capacity and one past it. It then drains the whole FIFO and compares every sample, which shows that the discarded write did not overwrite stored data and that the pointer wrap works at a capacity that is not a power of two. The frame count is checked while partial frames are held, including mixed pushes and pops that move the remainder across a frame boundary in both directions.

// File: rtl/asf_pkg.sv
package asf_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_e;

    localparam int CTL_CLR_BIT    = 0;
    localparam int CTL_NARROW_BIT = 12;
    localparam int CTL_IRQ_BIT    = 20;
    localparam int ST_UNDER_BIT   = 0;
    localparam int ST_OVER_BIT    = 4;
    localparam int ST_FILL_LSB    = 8;
    localparam int ST_FILL_W      = 9;
    localparam int FILL_SAT       = (1 << ST_FILL_W) - 1;

    // log2 of the channel count rounded up to a power of two
    function automatic int ch_shift(input int ch);
        int s;
        s = 0;
        for (int i = 0; i < 16; i++) begin
            if ((1 << i) < ch) s = i + 1;
        end
        return s;
    endfunction
endpackage

// File: rtl/asf_store.sv
module asf_store #(
    parameter int DW        = 24,
    parameter int MEM_WORDS = 256,
    parameter int AW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_ok,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_ok,
    input  logic [AW:0]   cap_words,
    output logic [DW-1:0] head_data
);
    logic [DW-1:0] mem [MEM_WORDS];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   last_idx;

    assign last_idx  = cap_words - (AW+1)'(1);
    assign head_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_ok) wr_ptr <= ({1'b0, wr_ptr} == last_idx) ? '0 : wr_ptr + AW'(1);
            if (rd_ok) rd_ptr <= ({1'b0, rd_ptr} == last_idx) ? '0 : rd_ptr + AW'(1);
        end
    end

    AST_WPTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, wr_ptr} < cap_words)); // R1
    AST_RPTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_ptr} < cap_words)); // R1
endmodule

// File: rtl/asf_level.sv
module asf_level
    import asf_pkg::*;
#(
    parameter int CNT_W = 9,
    parameter int CH_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 push_req,
    input  logic                 pop_req,
    input  logic [CH_W-1:0]      chan,
    input  logic [CNT_W-1:0]     cap_words,
    output logic                 push_ok,
    output logic                 pop_ok,
    output logic [CNT_W-1:0]     words,
    output logic [ST_FILL_W-1:0] frames_out,
    output occ_state_e           state
);
    occ_state_e       state_n;
    logic [CNT_W-1:0] frames_q;
    logic [CH_W-1:0]  rem_q;

    always_comb begin
        push_ok = push_req && (state != ST_FULL);
        pop_ok  = pop_req && (state != ST_EMPTY);
    end

    always_comb begin
        state_n = state;
        if (clr) begin
            state_n = ST_EMPTY;
        end else begin
            unique case (state)
                ST_EMPTY: begin
                    if (push_ok) state_n = ST_PARTIAL;
                end
                ST_PARTIAL: begin
                    if (push_ok && !pop_ok && (words == cap_words - CNT_W'(1)))
                        state_n = ST_FULL;
                    else if (pop_ok && !push_ok && (words == CNT_W'(1)))
                        state_n = ST_EMPTY;
                end
                ST_FULL: begin
                    if (pop_ok) state_n = ST_PARTIAL;
                end
                default: state_n = ST_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words    <= '0;
            frames_q <= '0;
            rem_q    <= '0;
        end else if (clr) begin
            words    <= '0;
            frames_q <= '0;
            rem_q    <= '0;
        end else if (push_ok && !pop_ok) begin
            words <= words + CNT_W'(1);
            if (rem_q == chan - CH_W'(1)) begin
                rem_q    <= '0;
                frames_q <= frames_q + CNT_W'(1);
            end else begin
                rem_q <= rem_q + CH_W'(1);
            end
        end else if (pop_ok && !push_ok) begin
            words <= words - CNT_W'(1);
            if (rem_q == '0) begin
                rem_q    <= chan - CH_W'(1);
                frames_q <= frames_q - CNT_W'(1);
            end else begin
                rem_q <= rem_q - CH_W'(1);
            end
        end
    end

    assign frames_out = (frames_q > CNT_W'(FILL_SAT)) ? ST_FILL_W'(FILL_SAT)
                                                      : frames_q[ST_FILL_W-1:0];

    AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (words <= cap_words)); // R1
    AST_FULL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) |-> (words == cap_words)); // R1
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL && push_req && !pop_req && !clr) |=> $stable(words)); // R3
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY && pop_req && !push_req && !clr) |=> (words == '0)); // R4
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (words == '0 && state == ST_EMPTY && frames_q == '0)); // R6
    AST_REM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_q < chan)); // R2
endmodule

// File: rtl/asf_flags.sv
module asf_flags #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             over_evt,
    input  logic             under_evt,
    input  logic             st_wr,
    input  logic             st_keep_over,
    input  logic             st_keep_under,
    input  logic             irq_en,
    input  logic             capture,
    input  logic [CNT_W-1:0] words,
    input  logic [CNT_W-1:0] cap_words,
    output logic             over_q,
    output logic             under_q,
    output logic             irq_req
);
    logic [CNT_W-1:0] half;

    assign half = cap_words >> 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            over_q  <= 1'b0;
            under_q <= 1'b0;
        end else begin
            over_q  <= (st_wr ? (over_q & st_keep_over) : over_q) | over_evt;
            under_q <= (st_wr ? (under_q & st_keep_under) : under_q) | under_evt;
        end
    end

    always_comb begin
        if (!irq_en)      irq_req = 1'b0;
        else if (capture) irq_req = (words >= half);
        else              irq_req = (words <= half);
    end

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (over_q && !st_wr) |=> over_q); // R5
    AST_UND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (under_q && !st_wr) |=> under_q); // R5
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        over_evt |=> over_q); // R3
    AST_UND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        under_evt |=> under_q); // R4
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
    import asf_pkg::*;
#(
    parameter int SIZE_CODE = 0,
    parameter int DW        = 24,
    parameter int CH_W      = 4,
    parameter int MAX_CH    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    cfg_chan,
    input  logic          cfg_capture,
    input  logic          ctl_wr,
    input  logic [31:0]   ctl_wdata,
    output logic [31:0]   ctl_rdata,
    input  logic          st_wr,
    input  logic [31:0]   st_wdata,
    output logic [31:0]   st_rdata,
    input  logic          host_wr,
    input  logic [23:0]   host_wdata,
    input  logic          host_rd,
    output logic [23:0]   host_rdata,
    input  logic          str_push,
    input  logic [23:0]   str_pdata,
    input  logic          str_pop,
    output logic [23:0]   str_qdata,
    output logic          irq_req
);
    localparam int MEM_WORDS = 256 << SIZE_CODE;
    localparam int AW        = $clog2(MEM_WORDS);
    localparam int CNT_W     = AW + 1;

    logic [CH_W-1:0]  chan_q;
    logic             capture_q;
    logic             irq_en_q;
    logic             narrow_q;
    logic             clr;
    logic [CH_W-1:0]  chan_clamped;
    logic [CNT_W-1:0] per_ch;
    logic [CNT_W-1:0] cap_words;
    logic             push_req;
    logic             pop_req;
    logic             push_ok;
    logic             pop_ok;
    logic [DW-1:0]    push_data;
    logic [DW-1:0]    head_raw;
    logic [DW-1:0]    head;
    logic [CNT_W-1:0] words;
    logic [ST_FILL_W-1:0] frames;
    occ_state_e       occ;
    logic             over_q;
    logic             under_q;
    logic             unused_bits;

    assign unused_bits = ^{ctl_wdata, st_wdata};

    assign clr = ctl_wr && ctl_wdata[CTL_CLR_BIT];

    always_comb begin
        if (cfg_chan == '0)                  chan_clamped = CH_W'(1);
        else if (cfg_chan > CH_W'(MAX_CH))   chan_clamped = CH_W'(MAX_CH);
        else                                 chan_clamped = cfg_chan;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q    <= CH_W'(1);
            capture_q <= 1'b0;
            irq_en_q  <= 1'b0;
            narrow_q  <= 1'b0;
        end else if (ctl_wr) begin
            irq_en_q <= ctl_wdata[CTL_IRQ_BIT];
            narrow_q <= ctl_wdata[CTL_NARROW_BIT];
            if (clr) begin
                chan_q    <= chan_clamped;
                capture_q <= cfg_capture;
            end
        end
    end

    always_comb begin
        per_ch    = CNT_W'(MEM_WORDS >> ch_shift(int'(chan_q)));
        cap_words = per_ch * CNT_W'(chan_q);
    end

    always_comb begin
        push_req = !clr && (capture_q ? str_push : host_wr);
        pop_req  = !clr && (capture_q ? host_rd : str_pop);
        if (capture_q)     push_data = str_pdata;
        else if (narrow_q) push_data = {host_wdata[15:0], {(DW-16){1'b0}}};
        else               push_data = host_wdata;
    end

    asf_level #(.CNT_W(CNT_W), .CH_W(CH_W)) u_level (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .push_req(push_req), .pop_req(pop_req),
        .chan(chan_q), .cap_words(cap_words),
        .push_ok(push_ok), .pop_ok(pop_ok),
        .words(words), .frames_out(frames), .state(occ)
    );

    asf_store #(.DW(DW), .MEM_WORDS(MEM_WORDS), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .wr_ok(push_ok), .wr_data(push_data),
        .rd_ok(pop_ok), .cap_words(cap_words),
        .head_data(head_raw)
    );

    asf_flags #(.CNT_W(CNT_W)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .over_evt(push_req && !push_ok),
        .under_evt(pop_req && !pop_ok),
        .st_wr(st_wr),
        .st_keep_over(st_wdata[ST_OVER_BIT]),
        .st_keep_under(st_wdata[ST_UNDER_BIT]),
        .irq_en(irq_en_q), .capture(capture_q),
        .words(words), .cap_words(cap_words),
        .over_q(over_q), .under_q(under_q), .irq_req(irq_req)
    );

    always_comb begin
        head = (occ == ST_EMPTY) ? '0 : head_raw;
        if (!capture_q)    host_rdata = '0;
        else if (narrow_q) host_rdata = {{(DW-16){1'b0}}, head[DW-1:DW-16]};
        else               host_rdata = head;
        str_qdata = capture_q ? '0 : head;
    end

    always_comb begin
        st_rdata = '0;
        st_rdata[ST_FILL_LSB +: ST_FILL_W] = frames;
        st_rdata[ST_OVER_BIT]  = over_q;
        st_rdata[ST_UNDER_BIT] = under_q;
        ctl_rdata = '0;
        ctl_rdata[CTL_IRQ_BIT]    = irq_en_q;
        ctl_rdata[CTL_NARROW_BIT] = narrow_q;
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ($stable(chan_q) && $stable(capture_q))); // R7
    AST_DIR_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_q && !clr && !str_push && !host_rd) |=> $stable(words)); // R8
    AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_q >= CH_W'(1) && chan_q <= CH_W'(MAX_CH))); // R7
endmodule

// File: tb/audio_sample_fifo_tb.sv
module audio_sample_fifo_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  cfg_chan;
    logic        cfg_capture;
    logic        ctl_wr;
    logic [31:0] ctl_wdata;
    logic [31:0] ctl_rdata;
    logic        st_wr;
    logic [31:0] st_wdata;
    logic [31:0] st_rdata;
    logic        host_wr;
    logic [23:0] host_wdata;
    logic        host_rd;
    logic [23:0] host_rdata;
    logic        str_push;
    logic [23:0] str_pdata;
    logic        str_pop;
    logic [23:0] str_qdata;
    logic        irq_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    audio_sample_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_chan(cfg_chan), .cfg_capture(cfg_capture),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .st_wr(st_wr), .st_wdata(st_wdata), .st_rdata(st_rdata),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .str_push(str_push), .str_pdata(str_pdata), .str_pop(str_pop), .str_qdata(str_qdata),
        .irq_req(irq_req)
    );

    // {op, data, expected frames}: op 0 = host write, 1 = stream pop (data is expected head)
    localparam logic [34:0] VEC [12] = '{
        {2'd0, 24'h111111, 9'd0}, {2'd0, 24'h222222, 9'd1},
        {2'd0, 24'h333333, 9'd1}, {2'd0, 24'h444444, 9'd2},
        {2'd0, 24'h555555, 9'd2}, {2'd1, 24'h111111, 9'd2},
        {2'd1, 24'h222222, 9'd1}, {2'd0, 24'h666666, 9'd2},
        {2'd1, 24'h333333, 9'd1}, {2'd1, 24'h444444, 9'd1},
        {2'd1, 24'h555555, 9'd0}, {2'd1, 24'h666666, 9'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] fr();
        return 32'(st_rdata[16:8]);
    endfunction

    task automatic do_clear(input logic [31:0] c, input logic [3:0] ch, input logic cap);
        cfg_chan = ch; cfg_capture = cap; ctl_wr = 1'b1; ctl_wdata = c;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic st_write(input logic [31:0] d);
        st_wr = 1'b1; st_wdata = d;
        @(negedge clk);
        st_wr = 1'b0;
    endtask

    task automatic hw(input logic [23:0] d);
        host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr();
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic sp(input logic [23:0] d);
        str_push = 1'b1; str_pdata = d;
        @(negedge clk);
        str_push = 1'b0;
    endtask

    task automatic sq();
        str_pop = 1'b1;
        @(negedge clk);
        str_pop = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int bad;
        rst_n = 1'b0; cfg_chan = 4'd1; cfg_capture = 1'b0;
        ctl_wr = 1'b0; ctl_wdata = '0; st_wr = 1'b0; st_wdata = '0;
        host_wr = 1'b0; host_wdata = '0; host_rd = 1'b0;
        str_push = 1'b0; str_pdata = '0; str_pop = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 status", st_rdata, 32'h0);
        chk("R12 control", ctl_rdata, 32'h0);
        chk("R12 irq", 32'(irq_req), 32'h0);
        chk("R12 empty head", 32'(str_qdata), 32'h0);

        // R2 R9 table walk, 2 channels playback
        do_clear(32'h1, 4'd2, 1'b0);
        for (int i = 0; i < 12; i++) begin
            if (VEC[i][34:33] == 2'd0) begin
                hw(VEC[i][32:9]);
            end else begin
                chk($sformatf("R9 head %0d", i), 32'(str_qdata), 32'(VEC[i][32:9]));
                sq();
            end
            chk($sformatf("R2 frames %0d", i), fr(), 32'(VEC[i][8:0]));
        end

        // R1 R3 3-channel capacity 192 words
        do_clear(32'h1, 4'd3, 1'b0);
        for (int i = 0; i < 192; i++) hw(24'h100000 + 24'(i));
        chk("R1 3ch full frames", st_rdata, 32'h4000);
        hw(24'hDEAD01);
        chk("R3 overrun flag", st_rdata, 32'h4010);
        bad = 0;
        for (int i = 0; i < 192; i++) begin
            if (str_qdata !== 24'h100000 + 24'(i)) bad++;
            sq();
        end
        chk("R9 drain order after wrap", 32'(bad), 32'h0);
        chk("R4 empty head zero", 32'(str_qdata), 32'h0);
        sq();
        chk("R4 underrun flag", st_rdata, 32'h11);

        // R5 sticky flags, AND write
        st_write(32'h10);
        chk("R5 keep overrun", st_rdata, 32'h10);
        st_write(32'h0);
        chk("R5 clear flags", st_rdata, 32'h0);

        // R1 5-channel capacity 160 words
        do_clear(32'h1, 4'd5, 1'b0);
        for (int i = 0; i < 160; i++) hw(24'(i));
        chk("R1 5ch full no error", st_rdata, 32'h2000);
        hw(24'h0000AA);
        chk("R3 5ch overrun", st_rdata, 32'h2010);

        // R6 clear keeps flags; R7 clamp 0 -> 1
        do_clear(32'h1, 4'd0, 1'b0);
        chk("R6 clear keeps flags", st_rdata, 32'h10);
        hw(24'h000001);
        chk("R7 count 0 as 1", fr(), 32'd1);
        // R7 pins ignored without clear
        cfg_chan = 4'd4; cfg_capture = 1'b1;
        hw(24'h000002);
        chk("R7 pin change ignored", fr(), 32'd2);
        // R7 clamp high -> 8
        do_clear(32'h1, 4'd15, 1'b0);
        for (int i = 0; i < 7; i++) hw(24'(i));
        chk("R7 count 15 partial", fr(), 32'd0);
        hw(24'h7);
        chk("R7 count 15 as 8", fr(), 32'd1);
        st_write(32'h0);

        // R6 clear wins over same-cycle write
        cfg_chan = 4'd1; cfg_capture = 1'b0;
        host_wr = 1'b1; host_wdata = 24'h777777;
        ctl_wr = 1'b1; ctl_wdata = 32'h1;
        @(negedge clk);
        host_wr = 1'b0; ctl_wr = 1'b0;
        chk("R6 clear drops write", st_rdata, 32'h0);
        chk("R6 clear head zero", 32'(str_qdata), 32'h0);

        // R10 playback request, 1 channel, half = 128
        do_clear(32'h100001, 4'd1, 1'b0);
        chk("R10 control readback", ctl_rdata, 32'h100000);
        chk("R10 play empty req", 32'(irq_req), 32'h1);
        for (int i = 0; i < 128; i++) hw(24'(i));
        chk("R10 play at half", 32'(irq_req), 32'h1);
        hw(24'h0);
        chk("R10 play above half", 32'(irq_req), 32'h0);

        // R8 R10 capture
        do_clear(32'h100001, 4'd1, 1'b1);
        chk("R10 cap empty req", 32'(irq_req), 32'h0);
        hw(24'h123456);
        chk("R8 host write ignored", fr(), 32'd0);
        for (int i = 0; i < 127; i++) sp(24'h200000 + 24'(i));
        chk("R10 cap below half", 32'(irq_req), 32'h0);
        sp(24'h20007F);
        chk("R10 cap at half", 32'(irq_req), 32'h1);
        sq();
        chk("R8 stream pop ignored", fr(), 32'd128);
        chk("R9 capture head", 32'(host_rdata), 32'h200000);
        hr();
        chk("R8 host read pops", fr(), 32'd127);
        chk("R9 capture next", 32'(host_rdata), 32'h200001);

        // R11 narrow packing
        do_clear(32'h1001, 4'd1, 1'b1);
        sp(24'hABCDEF);
        chk("R11 narrow read", 32'(host_rdata), 32'h00ABCD);
        do_clear(32'h1001, 4'd1, 1'b0);
        chk("R11 control readback", ctl_rdata, 32'h1000);
        hw(24'hFF1234);
        chk("R11 narrow write", 32'(str_qdata), 32'h123400);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule